// File: doc/BRIEF.md
# Set-Associative Address-to-ID Alias Table

This block turns wide addresses into short internal IDs so that companion tables can be indexed directly. A set-associative directory holds the current address-to-ID mappings. A queue of free IDs feeds new allocations. A requester can do three things. It can look an address up without side effects. It can look up and allocate, which returns the existing ID on a hit or installs a new mapping on a miss. It can release an address, which invalidates the mapping and recycles its ID.

The set index is taken from the request address starting at bit log2(size). The requester supplies that log2 value with every request. Objects that share low address bits but differ above their own size therefore spread across sets. The block never evicts anything. An allocation that finds its set full, or finds no free ID, is parked and stops further lookup traffic. Releases arriving on their own channel are still served. After each successful release the parked allocation is retried.

Top module: `alias_table`

## Requirements
- R1: A lookup (req_alloc=0) or allocation (req_alloc=1) whose address is present in its set returns rsp_hit=1 and the ID stored for that address, and changes no state.
- R2: An allocation that misses installs the address and returns rsp_hit=0 with the ID taken from the free queue. After reset the queue yields IDs 0, 1, 2, … NUM_IDS-1 in ascending order, followed by released IDs in the order they were released.
- R3: The set index bit k equals address bit (req_lgsz + k). Any such bit position at or above ADDR_W reads as zero. The same address presented with a different req_lgsz may therefore land in a different set.
- R4: A set holds at most WAYS entries. An allocation that misses in a full set produces no response and holds req_ready low. It completes after a release frees an ID and makes room in that set.
- R5: An allocation that misses while the free queue is empty produces no response and holds req_ready low until a successful release. It then completes with the released ID when no other free ID is queued ahead of it.
- R6: A lookup that misses returns rsp_hit=0 and rsp_id=0. It installs nothing and consumes no ID.
- R7: A release (rel_addr, rel_lgsz) of a present address returns rel_found=1 and its ID. Later lookups of that address miss. A release of an absent address returns rel_found=0, rel_id=0 and changes nothing.
- R8: One operation is in flight at a time. An accepted request or release reports its result two clock edges after the accepting edge. When rel_valid and req_valid are both high, the release is taken first and req_ready is low.
- R9: Reset empties the directory, refills the free queue, and leaves req_ready=1, rel_ready=1, rsp_valid=0 and rel_done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup/allocate request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_alloc | input | 1 | 1 = allocate on miss, 0 = lookup only |
| req_addr | input | ADDR_W | Address to translate |
| req_lgsz | input | LG_W | log2 of the object size; start of set index bits |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release accepted on this edge when high |
| rel_addr | input | ADDR_W | Address to release |
| rel_lgsz | input | LG_W | log2 size used when the address was allocated |
| rsp_valid | output | 1 | One-cycle pulse: request result valid |
| rsp_hit | output | 1 | Address was already present |
| rsp_id | output | ID_W | ID of the address (0 on lookup miss) |
| rel_done | output | 1 | One-cycle pulse: release result valid |
| rel_found | output | 1 | Released address was present |
| rel_id | output | ID_W | ID returned to the free queue (0 if not found) |

## Verification
A corrupted valid bit or tag shows up in the very next response. It appears as a false hit, a missing hit, or a set that stalls early or fails to stall. The bench catches this by filling one set exactly and probing it with an address whose high bits alias into it. A wrong free-queue pointer or counter stays hidden while fresh IDs remain. It surfaces only after the queue has drained, as a wrong recycled ID or a missed stall, so the directed tests exhaust the ID space and then recycle IDs in a known order. A lost retry flag shows as a parked allocation that never answers after a successful release.

// File: rtl/alias_pkg.sv
package alias_pkg;
  typedef enum logic [1:0] {
    K_LOOKUP  = 2'd0,
    K_ALLOC   = 2'd1,
    K_RELEASE = 2'd2
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;
endpackage

// File: rtl/alias_way_pick.sv
module alias_way_pick #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:0] cand,
  output logic [WAYS-1:0] pick_oh,
  output logic            any
);
  always_comb begin
    logic seen;
    seen    = 1'b0;
    pick_oh = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && !seen) begin
        pick_oh[w] = 1'b1;
        seen       = 1'b1;
      end
    end
    any = seen;
  end
endmodule

// File: rtl/alias_way_bank.sv
module alias_way_bank #(
  parameter int DEPTH = 256,
  parameter int TAG_W = 64,
  parameter int ID_W  = 11,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [ID_W-1:0]  rd_id,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [ID_W-1:0]  wr_id
);
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [ID_W-1:0]  id_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      id_mem[wr_idx]  <= wr_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag <= tag_mem[rd_idx];
      rd_id  <= id_mem[rd_idx];
    end
  end
endmodule

// File: rtl/alias_free_ids.sv
module alias_free_ids #(
  parameter int NUM_IDS = 2048,
  parameter int ID_W    = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  output logic            avail,
  output logic [ID_W-1:0] head_id
);
  localparam logic [ID_W:0]   LIMIT = (ID_W+1)'(NUM_IDS);
  localparam logic [ID_W-1:0] LAST  = ID_W'(NUM_IDS - 1);

  logic [ID_W-1:0] ring [NUM_IDS];
  logic [ID_W:0]   fresh_q, cnt_q;
  logic [ID_W-1:0] rp_q, wp_q;
  logic            fresh_left, pop_ring;

  assign fresh_left = (fresh_q < LIMIT);
  assign avail      = fresh_left || (cnt_q != '0);
  assign head_id    = fresh_left ? fresh_q[ID_W-1:0] : ring[rp_q];
  assign pop_ring   = pop && !fresh_left;

  always_ff @(posedge clk) begin
    if (push) ring[wp_q] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= '0;
      cnt_q   <= '0;
      rp_q    <= '0;
      wp_q    <= '0;
    end else begin
      if (pop && fresh_left) fresh_q <= fresh_q + 1'b1;
      if (pop_ring) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push)     wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      cnt_q <= cnt_q + (ID_W+1)'(push) - (ID_W+1)'(pop_ring);
    end
  end
endmodule

// File: rtl/alias_table.sv
module alias_table
  import alias_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int NUM_IDS = 2048,
  parameter int WAYS    = 8,
  parameter int SETS    = NUM_IDS / WAYS,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int LG_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_alloc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LG_W-1:0]   req_lgsz,
  input  logic              rel_valid,
  output logic              rel_ready,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic [LG_W-1:0]   rel_lgsz,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rel_done,
  output logic              rel_found,
  output logic [ID_W-1:0]   rel_id
);
  localparam int SET_W = $clog2(SETS);

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a,
                                              input logic [LG_W-1:0]   lg);
    logic [SET_W-1:0] s;
    int               b;
    for (int k = 0; k < SET_W; k++) begin
      b    = int'(lg) + k;
      s[k] = (b < ADDR_W) ? a[b] : 1'b0;
    end
    return s;
  endfunction

  state_e            state_q;
  kind_e             cur_kind_q, src_kind;
  logic [ADDR_W-1:0] cur_addr_q, park_addr_q, src_addr;
  logic [SET_W-1:0]  cur_set_q, park_set_q, src_set;
  logic              parked_q, retry_q;
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   rd_vld_q;

  logic take_rel, take_retry, take_req, issue;

  // Source selection: releases first, then a pending retry, then new requests
  always_comb begin
    take_rel   = rel_valid;
    take_retry = !rel_valid && parked_q && retry_q;
    take_req   = !rel_valid && !parked_q && req_valid;
    issue      = (state_q == ST_IDLE) && (take_rel || take_retry || take_req);
    src_kind   = K_LOOKUP;
    src_addr   = req_addr;
    src_set    = set_of(req_addr, req_lgsz);
    if (take_rel) begin
      src_kind = K_RELEASE;
      src_addr = rel_addr;
      src_set  = set_of(rel_addr, rel_lgsz);
    end else if (take_retry) begin
      src_kind = K_ALLOC;
      src_addr = park_addr_q;
      src_set  = park_set_q;
    end else if (req_alloc) begin
      src_kind = K_ALLOC;
    end
  end

  assign rel_ready = (state_q == ST_IDLE);
  assign req_ready = (state_q == ST_IDLE) && !parked_q && !rel_valid;

  // Way storage
  logic [ADDR_W-1:0] bank_tag [WAYS];
  logic [ID_W-1:0]   bank_id  [WAYS];
  logic [WAYS-1:0]   bank_we;
  logic [ID_W-1:0]   new_id;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    alias_way_bank #(
      .DEPTH (SETS),
      .TAG_W (ADDR_W),
      .ID_W  (ID_W)
    ) u_bank (
      .clk    (clk),
      .rd_en  (issue),
      .rd_idx (src_set),
      .rd_tag (bank_tag[w]),
      .rd_id  (bank_id[w]),
      .wr_en  (bank_we[w]),
      .wr_idx (cur_set_q),
      .wr_tag (cur_addr_q),
      .wr_id  (new_id)
    );
  end

  // Compare stage
  logic [WAYS-1:0] hit_vec, pick_oh;
  logic            hit_any, pick_any;
  logic [ID_W-1:0] hit_id;

  always_comb begin
    hit_id = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_vld_q[w] && (bank_tag[w] == cur_addr_q);
      if (hit_vec[w]) hit_id = hit_id | bank_id[w];
    end
    hit_any = |hit_vec;
  end

  alias_way_pick #(.WAYS(WAYS)) u_pick (
    .cand    (~rd_vld_q),
    .pick_oh (pick_oh),
    .any     (pick_any)
  );

  logic in_exec, free_avail, alloc_ok, park_now, rel_hit;

  assign in_exec  = (state_q == ST_EXEC);
  assign alloc_ok = in_exec && (cur_kind_q == K_ALLOC) && !hit_any && pick_any && free_avail;
  assign park_now = in_exec && (cur_kind_q == K_ALLOC) && !hit_any && !(pick_any && free_avail);
  assign rel_hit  = in_exec && (cur_kind_q == K_RELEASE) && hit_any;
  assign bank_we  = alloc_ok ? pick_oh : '0;

  alias_free_ids #(
    .NUM_IDS (NUM_IDS),
    .ID_W    (ID_W)
  ) u_free (
    .clk     (clk),
    .rst     (rst),
    .pop     (alloc_ok),
    .push    (rel_hit),
    .push_id (hit_id),
    .avail   (free_avail),
    .head_id (new_id)
  );

  // Control, directory valid bits and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_kind_q  <= K_LOOKUP;
      cur_addr_q  <= '0;
      cur_set_q   <= '0;
      park_addr_q <= '0;
      park_set_q  <= '0;
      parked_q    <= 1'b0;
      retry_q     <= 1'b0;
      rd_vld_q    <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_id      <= '0;
      rel_done    <= 1'b0;
      rel_found   <= 1'b0;
      rel_id      <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rel_done  <= 1'b0;
      if (issue) begin
        state_q    <= ST_EXEC;
        cur_kind_q <= src_kind;
        cur_addr_q <= src_addr;
        cur_set_q  <= src_set;
        rd_vld_q   <= vld_q[src_set];
      end
      if (in_exec) begin
        state_q <= ST_IDLE;
        unique case (cur_kind_q)
          K_LOOKUP: begin
            rsp_valid <= 1'b1;
            rsp_hit   <= hit_any;
            rsp_id    <= hit_any ? hit_id : '0;
          end
          K_ALLOC: begin
            if (park_now) begin
              parked_q    <= 1'b1;
              retry_q     <= 1'b0;
              park_addr_q <= cur_addr_q;
              park_set_q  <= cur_set_q;
            end else begin
              parked_q  <= 1'b0;
              retry_q   <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_hit   <= hit_any;
              rsp_id    <= hit_any ? hit_id : new_id;
            end
            if (alloc_ok) vld_q[cur_set_q] <= rd_vld_q | pick_oh;
          end
          K_RELEASE: begin
            rel_done  <= 1'b1;
            rel_found <= hit_any;
            rel_id    <= hit_any ? hit_id : '0;
            if (hit_any) begin
              vld_q[cur_set_q] <= rd_vld_q & ~hit_vec;
              if (parked_q) retry_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/alias_table_chk.sv
module alias_table_chk #(
  parameter int NUM_IDS = 2048,
  parameter int ID_W    = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_alloc,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [ID_W-1:0] rsp_id,
  input logic            rel_valid,
  input logic            rel_ready,
  input logic            rel_done,
  input logic            rel_found
);
  logic          last_alloc_q;
  logic [ID_W:0] live_q;
  logic          new_map;

  assign new_map = rsp_valid && last_alloc_q && !rsp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_alloc_q <= 1'b0;
      live_q       <= '0;
    end else begin
      if (req_valid && req_ready) last_alloc_q <= req_alloc;
      live_q <= live_q + (ID_W+1)'(new_map) - (ID_W+1)'(rel_done && rel_found);
    end
  end

  AST_LOOKUP_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !last_alloc_q && !rsp_hit |-> rsp_id == '0); // R6

  AST_ALLOC_NEEDS_ID: assert property (@(posedge clk) disable iff (rst)
    new_map |-> live_q < (ID_W+1)'(NUM_IDS)); // R5

  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> ##2 (rsp_valid || !req_ready)); // R8

  AST_REL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rel_valid && rel_ready |-> ##2 rel_done); // R7

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) || (rel_valid && rel_ready) |=> !req_ready && !rel_ready); // R8

  AST_SINGLE_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
endmodule

bind alias_table alias_table_chk #(
  .NUM_IDS (NUM_IDS),
  .ID_W    (ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_alloc (req_alloc),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_id    (rsp_id),
  .rel_valid (rel_valid),
  .rel_ready (rel_ready),
  .rel_done  (rel_done),
  .rel_found (rel_found)
);

// File: tb/tb_alias_table.sv
`timescale 1ns/1ps
module tb_alias_table;
  localparam int ADDR_W  = 64;
  localparam int NUM_IDS = 8;
  localparam int WAYS    = 4;
  localparam int SETS    = 4;
  localparam int ID_W    = $clog2(NUM_IDS);
  localparam int LG_W    = $clog2(ADDR_W);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_alloc = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LG_W-1:0]   req_lgsz = '0;
  logic              rel_valid = 1'b0;
  logic [ADDR_W-1:0] rel_addr = '0;
  logic [LG_W-1:0]   rel_lgsz = '0;
  logic              req_ready, rel_ready, rsp_valid, rsp_hit, rel_done, rel_found;
  logic [ID_W-1:0]   rsp_id, rel_id;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  alias_table #(
    .ADDR_W (ADDR_W), .NUM_IDS (NUM_IDS), .WAYS (WAYS), .SETS (SETS)
  ) dut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready), .req_alloc (req_alloc),
    .req_addr (req_addr), .req_lgsz (req_lgsz),
    .rel_valid (rel_valid), .rel_ready (rel_ready),
    .rel_addr (rel_addr), .rel_lgsz (rel_lgsz),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_id (rsp_id),
    .rel_done (rel_done), .rel_found (rel_found), .rel_id (rel_id)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; rel_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_req(input bit alloc, input logic [ADDR_W-1:0] a, input int lg);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_alloc = alloc; req_addr = a; req_lgsz = LG_W'(lg);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int max, output bit got, output int lat,
                          output bit hit, output int id);
    got = 0; lat = 0; hit = 0; id = 0;
    for (int i = 1; i <= max; i++) begin
      if (!got) begin
        @(negedge clk);
        if (rsp_valid) begin
          got = 1; lat = i; hit = rsp_hit; id = int'(rsp_id);
        end
      end
    end
  endtask

  task automatic do_req(input string rq, input bit alloc, input logic [ADDR_W-1:0] a,
                        input int lg, input bit exp_hit, input int exp_id);
    bit got, hit; int lat, id;
    send_req(alloc, a, lg);
    wait_rsp(4, got, lat, hit, id);
    check(rq, "response seen", got, 1);
    check("R8", "response latency", lat, 1);
    check(rq, "hit", hit, exp_hit);
    check(rq, "id", id, exp_id);
  endtask

  task automatic do_rel(input string rq, input logic [ADDR_W-1:0] a, input int lg,
                        input bit exp_found, input int exp_id);
    while (!rel_ready) @(negedge clk);
    rel_valid = 1'b1; rel_addr = a; rel_lgsz = LG_W'(lg);
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    @(negedge clk);
    check(rq, "rel_done", rel_done, 1);
    check(rq, "rel_found", rel_found, exp_found);
    check(rq, "rel_id", rel_id, exp_id);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9", "req_ready", req_ready, 1);
    check("R9", "rel_ready", rel_ready, 1);
    check("R9", "rsp_valid", rsp_valid, 0);
    check("R9", "rel_done", rel_done, 0);
  endtask

  task automatic t_basic();
    do_reset();
    do_req("R2", 1, 64'h1000, 12, 0, 0);
    do_req("R1", 1, 64'h1000, 12, 1, 0);
    do_req("R1", 0, 64'h1000, 12, 1, 0);
    do_req("R6", 0, 64'h2000, 12, 0, 0);
    do_req("R6", 1, 64'h2000, 12, 0, 1);
    do_req("R1", 0, 64'h2000, 12, 1, 1);
  endtask

  task automatic t_priority();
    do_reset();
    @(negedge clk);
    rel_valid = 1'b1; rel_addr = 64'h7700; rel_lgsz = 6'd8;
    req_valid = 1'b1; req_alloc = 1'b0; req_addr = 64'h5000; req_lgsz = 6'd12;
    #1;
    check("R8", "req_ready while release pending", req_ready, 0);
    check("R8", "rel_ready", rel_ready, 1);
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
    @(negedge clk);
    check("R8", "release answered first", rel_done, 1);
    check("R7", "absent release found", rel_found, 0);
    check("R8", "request not answered yet", rsp_valid, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R8", "request answered after release", rsp_valid, 1);
    check("R6", "lookup miss hit", rsp_hit, 0);
  endtask

  task automatic t_index_and_full_set();
    bit got, hit; int lat, id;
    do_reset();
    do_req("R2", 1, 64'h3000, 12, 0, 0);
    do_req("R2", 1, 64'h7000, 12, 0, 1);
    do_req("R2", 1, 64'hB000, 12, 0, 2);
    do_req("R2", 1, 64'hF000, 12, 0, 3);
    // bits 63:62 = 11 select set 3, already full
    send_req(1, 64'hC000_0000_0000_0000, 62);
    wait_rsp(8, got, lat, hit, id);
    check("R4", "no response on full set", got, 0);
    check("R3", "high-bit index reaches full set", req_ready, 0);
    do_rel("R7", 64'hB000, 12, 1, 2);
    wait_rsp(6, got, lat, hit, id);
    check("R4", "parked alloc completes", got, 1);
    check("R4", "parked alloc id", id, 4);
    check("R4", "parked alloc hit", hit, 0);
    do_req("R3", 1, 64'h3000, 4, 0, 5);
    do_req("R3", 1, 64'h13000, 16, 0, 6);
    do_req("R1", 0, 64'hC000_0000_0000_0000, 62, 1, 4);
  endtask

  task automatic t_queue_empty();
    bit got, hit; int lat, id;
    do_reset();
    for (int i = 0; i < 8; i++) do_req("R2", 1, 64'(i) << 12, 12, 0, i);
    send_req(1, 64'h8000, 12);
    wait_rsp(8, got, lat, hit, id);
    check("R5", "no response with empty queue", got, 0);
    check("R5", "req_ready low while parked", req_ready, 0);
    do_rel("R7", 64'h5000, 12, 1, 5);
    wait_rsp(6, got, lat, hit, id);
    check("R5", "parked alloc completes", got, 1);
    check("R5", "recycled id", id, 5);
    do_rel("R7", 64'h2000, 12, 1, 2);
    do_rel("R7", 64'h6000, 12, 1, 6);
    do_req("R2", 1, 64'h9000, 12, 0, 2);
    do_req("R2", 1, 64'hA000, 12, 0, 6);
  endtask

  task automatic t_release();
    do_reset();
    do_req("R9", 0, 64'h9000, 12, 0, 0);
    do_req("R2", 1, 64'h4000, 12, 0, 0);
    do_rel("R7", 64'h5000, 12, 0, 0);
    do_req("R7", 0, 64'h4000, 12, 1, 0);
    do_rel("R7", 64'h4000, 12, 1, 0);
    do_req("R7", 0, 64'h4000, 12, 0, 0);
    do_rel("R7", 64'h4000, 12, 0, 0);
    do_req("R2", 1, 64'h4000, 12, 0, 1);
  endtask

  initial begin
    t_reset_state();
    t_basic();
    t_priority();
    t_index_and_full_set();
    t_queue_empty();
    t_release();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule